// File: doc/BRIEF.md
# Ping-Pong USB IN Endpoint Transmit Buffer

This block is the device-side staging store for a single USB IN endpoint. A CPU-side port pushes bytes into the bank currently open for filling. It then pulses a packet-enable input, which freezes that bank's byte count and hands the bank to the transmit side. The transmit side walks the oldest committed packet one byte at a time. A last-byte flag marks the final byte, and a done pulse returns the bank once the host has taken the packet. When nothing is committed, a not-ready output is raised instead of data.

A mode input selects between one bank and two ping-pong banks. In two-bank mode every commit moves the fill side to the other bank, so the CPU can load the next packet while the previous one is being sent. A data-status output is high while any committed packet is still unsent. A one-shot clear input empties both banks at once, discarding committed and partly written data alike.

Top module: `usb_in_ep_buffer`

## Requirements
- R1: After reset, data_status is 0, tx_nrdy is 1, wr_ready is 1 and tx_count is 0.
- R2: Bytes accepted while wr_ready is 1 are kept in arrival order. A commit latches the bank's byte count, including a byte written in the same cycle as pkt_enable. tx_count shows that count while the packet is offered.
- R3: data_status is 1 in the cycle after a commit of a bank holding at least one byte. A pkt_enable pulse on an empty bank is ignored.
- R4: While a packet is offered, tx_data shows the byte at the read position. tx_rd advances the read position by one. tx_last is 1 exactly on the final byte, and a tx_rd on the final byte leaves tx_data and tx_last unchanged.
- R5: In single-bank mode, a tx_done pulse on an offered packet releases the bank. data_status falls to 0, tx_nrdy rises and wr_ready rises in the next cycle.
- R6: In single-bank mode, while a packet is committed, wr_ready is 0, and both writes and further commits are ignored.
- R7: In two-bank mode, a commit switches filling to the other bank, so wr_ready stays 1 while that bank is free. Packets are offered in commit order.
- R8: In two-bank mode, data_status falls to 0 only when both banks are empty. A commit in the same cycle as tx_done of the other bank keeps data_status at 1, and the new packet is offered in the next cycle.
- R9: A bank holds DEPTH (default 64) bytes. When the fill bank is full, wr_ready is 0 and extra writes are discarded.
- R10: A clr_strobe pulse discards committed and uncommitted bytes in both banks. In the next cycle data_status is 0, tx_nrdy is 1, wr_ready is 1 and tx_count is 0, and filling restarts at byte 0.
- R11: status_byte carries data_status in bit 0, and bits 7 to 1 always read 0.
- R12: tx_rd and tx_done pulses while tx_nrdy is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_mode | input | 1 | 1 selects two ping-pong banks; change only while empty |
| wr_valid | input | 1 | CPU byte write strobe |
| wr_data | input | DW | CPU byte |
| pkt_enable | input | 1 | Commit pulse for the fill bank |
| clr_strobe | input | 1 | One-shot clear of both banks |
| tx_rd | input | 1 | Advance to the next byte of the offered packet |
| tx_done | input | 1 | Offered packet delivered; release its bank |
| wr_ready | output | 1 | Fill bank can accept a byte |
| data_status | output | 1 | Committed, unsent data present |
| status_byte | output | 8 | Status readback: bit 0 is data_status, others 0 |
| tx_nrdy | output | 1 | No committed packet to offer |
| tx_data | output | DW | Byte at the read position |
| tx_last | output | 1 | Read position is the packet's final byte |
| tx_count | output | CW | Byte count of the offered packet |

## Verification
In two-bank mode, the release of the bank being sent and the commit of the other bank can land in the same cycle. Whether data_status survives that cycle decides whether the host sees a gap. The bench provokes it by reading a packet to its last byte by hand. It then drives tx_done together with the final write and pkt_enable for the other bank. It judges the result by data_status staying 1, the second packet being offered in the next cycle with its latched count, and its bytes coming out in order.

// File: rtl/usb_in_ep_buffer.sv
module usb_in_ep_buffer #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int PW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dual_mode,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          pkt_enable,
  input  logic          clr_strobe,
  input  logic          tx_rd,
  input  logic          tx_done,
  output logic          wr_ready,
  output logic          data_status,
  output logic [7:0]    status_byte,
  output logic          tx_nrdy,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  output logic [CW-1:0] tx_count
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [2][DEPTH];
  logic [CW-1:0] cnt [2];
  logic [1:0]    cmt;
  logic [PW-1:0] rptr;
  logic          fb, sb;

  logic fill_free, wr_en, commit_en, send_ok, is_last, adv_en, done_en;

  assign fill_free = !cmt[fb] && (cnt[fb] < FULL);
  assign wr_en     = wr_valid && fill_free && !clr_strobe;
  assign commit_en = pkt_enable && !cmt[fb] && !clr_strobe && ((cnt[fb] != '0) || wr_en);
  assign send_ok   = cmt[sb];
  assign is_last   = (CW'(rptr) + CW'(1)) == cnt[sb];
  assign adv_en    = tx_rd && send_ok && !is_last && !tx_done && !clr_strobe;
  assign done_en   = tx_done && send_ok && !clr_strobe;

  always_ff @(posedge clk) begin
    if (wr_en) mem[fb][cnt[fb][PW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_strobe) begin
      for (int b = 0; b < 2; b++) cnt[b] <= '0;
      cmt <= '0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (done_en && (sb == 1'(b))) begin
          cmt[b] <= 1'b0;
          cnt[b] <= '0;
        end
        if ((fb == 1'(b)) && wr_en) cnt[b] <= cnt[b] + CW'(1);
        if ((fb == 1'(b)) && commit_en) cmt[b] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_strobe) begin
      fb   <= 1'b0;
      sb   <= 1'b0;
      rptr <= '0;
    end else begin
      if (commit_en && dual_mode) fb <= ~fb;
      if (done_en) begin
        rptr <= '0;
        if (dual_mode) sb <= ~sb;
      end else if (adv_en) begin
        rptr <= rptr + PW'(1);
      end
    end
  end

  assign wr_ready    = fill_free;
  assign data_status = |cmt;
  assign status_byte = {7'b0, data_status};
  assign tx_nrdy     = !send_ok;
  assign tx_data     = send_ok ? mem[sb][rptr] : '0;
  assign tx_last     = send_ok && is_last;
  assign tx_count    = send_ok ? cnt[sb] : '0;

endmodule

// File: rtl/usb_in_ep_buffer_chk.sv
module usb_in_ep_buffer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dual_mode,
  input logic          wr_valid,
  input logic          pkt_enable,
  input logic          clr_strobe,
  input logic          tx_rd,
  input logic          tx_done,
  input logic          wr_ready,
  input logic          data_status,
  input logic          tx_nrdy,
  input logic [DW-1:0] tx_data,
  input logic          tx_last
);

  AST_COMMIT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && pkt_enable && !clr_strobe) |=> data_status); // R3

  AST_SINGLE_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_mode && tx_done && !tx_nrdy && !clr_strobe) |=> !data_status); // R5

  AST_SINGLE_BLOCKS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_mode && data_status) |-> !wr_ready); // R6

  AST_LAST_BYTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last && tx_rd && !tx_done && !clr_strobe) |=> (tx_last && $stable(tx_data))); // R4

  AST_DUAL_SECOND_BANK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_mode && !data_status && wr_valid && wr_ready && pkt_enable && !clr_strobe) |=> wr_ready); // R7

  AST_SWAP_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_mode && tx_done && !tx_nrdy && wr_valid && wr_ready && pkt_enable && !clr_strobe)
    |=> (data_status && !tx_nrdy)); // R8

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_strobe |=> (!data_status && tx_nrdy && wr_ready)); // R10

  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_nrdy && !pkt_enable && !clr_strobe) |=> tx_nrdy); // R12

endmodule

bind usb_in_ep_buffer usb_in_ep_buffer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .wr_valid(wr_valid),
  .pkt_enable(pkt_enable), .clr_strobe(clr_strobe), .tx_rd(tx_rd), .tx_done(tx_done),
  .wr_ready(wr_ready), .data_status(data_status), .tx_nrdy(tx_nrdy),
  .tx_data(tx_data), .tx_last(tx_last)
);

// File: tb/usb_in_ep_buffer_bench.sv
module usb_in_ep_buffer_bench;
  localparam int DW = 8, DEPTH = 64, CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, dual_mode = 0, wr_valid = 0, pkt_enable = 0;
  logic clr_strobe = 0, tx_rd = 0, tx_done = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, data_status, tx_nrdy, tx_last;
  logic [7:0] status_byte;
  logic [DW-1:0] tx_data;
  logic [CW-1:0] tx_count;

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_q[$];
  int len_q[$];
  bit drain_en = 0;

  always #4 clk = ~clk;

  usb_in_ep_buffer #(.DW(DW), .DEPTH(DEPTH)) u_usb_in_ep_buffer (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .wr_valid(wr_valid),
    .wr_data(wr_data), .pkt_enable(pkt_enable), .clr_strobe(clr_strobe),
    .tx_rd(tx_rd), .tx_done(tx_done), .wr_ready(wr_ready), .data_status(data_status),
    .status_byte(status_byte), .tx_nrdy(tx_nrdy), .tx_data(tx_data),
    .tx_last(tx_last), .tx_count(tx_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_bytes(input int n, input int base, input bit last_commits);
    if (last_commits) len_q.push_back(n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 0; pkt_enable = 0;
      while (!wr_ready) @(negedge clk);
      wr_valid = 1;
      wr_data = DW'(base + i);
      pkt_enable = last_commits && (i == n - 1);
      exp_q.push_back(DW'(base + i));
    end
    @(negedge clk);
    wr_valid = 0; pkt_enable = 0;
  endtask

  task automatic commit_only(input int n);
    len_q.push_back(n);
    pkt_enable = 1;
    @(negedge clk);
    pkt_enable = 0;
  endtask

  task automatic manual_read();
    int len;
    len = len_q.pop_front();
    check(tx_count == CW'(len), "R2", tx_count, len);
    for (int k = 0; k < len; k++) begin
      logic [DW-1:0] e;
      e = exp_q.pop_front();
      check(tx_data == e, "R4", tx_data, e);
      check(tx_last == (k == len - 1), "R4", tx_last, k == len - 1);
      if (k < len - 1) begin
        tx_rd = 1; @(negedge clk); tx_rd = 0;
      end
    end
  endtask

  task automatic drain();
    drain_en = 1;
    while (len_q.size() > 0) @(negedge clk);
    @(negedge clk);
    drain_en = 0; tx_rd = 0; tx_done = 0;
  endtask

  task automatic pulse_clear();
    clr_strobe = 1; @(negedge clk); clr_strobe = 0;
    exp_q.delete(); len_q.delete();
  endtask

  // monitor: pops the scoreboard as the design presents bytes
  initial begin
    int k = 0;
    bit after_done = 0;
    forever begin
      @(negedge clk);
      if (drain_en) begin
        if (after_done && !dual_mode) check(data_status == 0, "R5", data_status, 0);
        after_done = 0;
        tx_rd = 0; tx_done = 0;
        if (!tx_nrdy && len_q.size() > 0) begin
          logic [DW-1:0] e;
          int len;
          len = len_q[0];
          if (k == 0) check(tx_count == CW'(len), "R2", tx_count, len);
          e = exp_q.pop_front();
          check(tx_data == e, "R4", tx_data, e);
          check(tx_last == (k == len - 1), "R4", tx_last, k == len - 1);
          if (k == len - 1) begin
            tx_done = 1; k = 0; void'(len_q.pop_front()); after_done = 1;
          end else begin
            tx_rd = 1; k++;
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(data_status == 0, "R1", data_status, 0);
    check(tx_nrdy == 1, "R1", tx_nrdy, 1);
    check(wr_ready == 1, "R1", wr_ready, 1);
    check(tx_count == 0, "R1", tx_count, 0);
    check(status_byte == 8'h00, "R11", status_byte, 0);

    // R12: transmit pulses with nothing committed
    tx_rd = 1; tx_done = 1; @(negedge clk); tx_rd = 0; tx_done = 0;
    check(tx_nrdy == 1, "R12", tx_nrdy, 1);
    check(data_status == 0, "R12", data_status, 0);

    // R3: commit of an empty bank
    pkt_enable = 1; @(negedge clk); pkt_enable = 0;
    check(data_status == 0, "R3", data_status, 0);

    // single bank: commit with the last byte, then blocked writes
    write_bytes(5, 8'h10, 1);
    check(data_status == 1, "R3", data_status, 1);
    check(status_byte == 8'h01, "R11", status_byte, 1);
    check(wr_ready == 0, "R6", wr_ready, 0);
    check(tx_count == 5, "R2", tx_count, 5);
    wr_valid = 1; wr_data = 8'hEE; pkt_enable = 1; @(negedge clk);
    wr_valid = 0; pkt_enable = 0;
    check(tx_count == 5, "R6", tx_count, 5);
    drain();
    check(data_status == 0, "R5", data_status, 0);
    check(tx_nrdy == 1, "R5", tx_nrdy, 1);
    check(wr_ready == 1, "R5", wr_ready, 1);

    // separate commit and back-to-back packets while draining
    drain_en = 1;
    write_bytes(3, 8'h20, 0);
    commit_only(3);
    write_bytes(7, 8'h30, 1);
    drain();

    // R9: full bank, extra bytes discarded
    write_bytes(DEPTH, 8'h80, 0);
    check(wr_ready == 0, "R9", wr_ready, 0);
    wr_valid = 1; wr_data = 8'hFF; repeat (2) @(negedge clk); wr_valid = 0;
    commit_only(DEPTH);
    check(tx_count == CW'(DEPTH), "R9", tx_count, DEPTH);
    drain();

    // R4: read past the last byte by hand
    write_bytes(3, 8'hA0, 1);
    manual_read();
    tx_rd = 1; @(negedge clk); tx_rd = 0;
    check(tx_last == 1, "R4", tx_last, 1);
    check(tx_data == 8'hA2, "R4", tx_data, 8'hA2);
    tx_done = 1; @(negedge clk); tx_done = 0;
    check(data_status == 0, "R5", data_status, 0);

    // two banks
    dual_mode = 1; @(negedge clk);
    write_bytes(4, 8'h40, 1);
    check(wr_ready == 1, "R7", wr_ready, 1);
    check(data_status == 1, "R3", data_status, 1);
    write_bytes(6, 8'h50, 1);
    check(wr_ready == 0, "R7", wr_ready, 0);
    check(tx_count == 4, "R7", tx_count, 4);
    drain();
    check(data_status == 0, "R8", data_status, 0);

    // R8: release of one bank and commit of the other in the same cycle
    write_bytes(4, 8'h60, 1);
    write_bytes(3, 8'h70, 0);
    manual_read();
    len_q.push_back(4);
    exp_q.push_back(8'h73);
    tx_done = 1; wr_valid = 1; wr_data = 8'h73; pkt_enable = 1;
    @(negedge clk);
    tx_done = 0; wr_valid = 0; pkt_enable = 0;
    check(data_status == 1, "R8", data_status, 1);
    check(tx_nrdy == 0, "R8", tx_nrdy, 0);
    check(tx_count == 4, "R2", tx_count, 4);
    check(wr_ready == 1, "R7", wr_ready, 1);
    drain();
    check(data_status == 0, "R8", data_status, 0);

    // R10: clear with committed and partial data in both banks
    write_bytes(3, 8'hC0, 1);
    write_bytes(2, 8'hD0, 0);
    pulse_clear();
    check(data_status == 0, "R10", data_status, 0);
    check(tx_nrdy == 1, "R10", tx_nrdy, 1);
    check(wr_ready == 1, "R10", wr_ready, 1);
    check(tx_count == 0, "R10", tx_count, 0);
    write_bytes(2, 8'hE0, 1);
    check(tx_count == 2, "R10", tx_count, 2);
    drain();

    // R10: clear in single-bank mode with only uncommitted bytes
    dual_mode = 0; @(negedge clk);
    write_bytes(5, 8'h90, 0);
    pulse_clear();
    write_bytes(1, 8'h33, 1);
    check(tx_count == 1, "R10", tx_count, 1);
    drain();
    check(status_byte == 8'h00, "R11", status_byte, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule